// File: doc/BRIEF.md
# Inclusive Cache Directory Slice with Snoop Filtering

This block holds the tags and the per-core presence directory for one slice of a shared, inclusive last-level cache. Every cached line keeps one presence bit for each core. The bit says that the core may hold a copy in its private caches. Each line also keeps an exclusive flag, which says that a single core took the line for ownership and may have modified it. A request names a line address, the requesting core, and whether the core wants a plain read or a read-for-ownership. The block answers one cycle later. The answer gives hit or miss, whether the data has to come from another core's modified copy, and a snoop command. The snoop command carries a core mask, a kind and a line address, and it is aimed only at the cores whose presence bits require it.

Addresses are spread over the slices by an XOR fold of the line address. A slice acts only on requests that fold to its own index. A miss allocates a way in its set, chosen first among invalid ways and otherwise by tree pseudo-LRU. The miss also raises a memory request for the missing line. If the displaced line still has holders, the block sends a back-invalidate to all of them so that inclusion is kept. When memory data later returns to a core, a fill notification sets that core's presence bit. Data storage, ring transport and DRAM timing lie outside this block. Fills and requests are assumed not to arrive in the same cycle.

Top module: `llc_snoop_dir`

## Requirements
- R1: After reset every line is invalid and all of rsp_valid, snp_valid and miss_valid are low, so the first request to any line misses.
- R2: A request is accepted only when the XOR of the line address bits, folded bit i into slice bit (i mod log2 cores), equals SLICE_ID. Any other request produces no response, no snoop and no miss, and changes no state.
- R3: An accepted request that misses sets rsp_valid=1, rsp_hit=0, miss_valid=1 and miss_addr=line address on the following cycle. The newly allocated entry has no presence bits set.
- R4: A fill sets the fill core's presence bit in the entry that matches the fill line. A fill to a line that is not present has no effect.
- R5: A read hit where no other core holds the line exclusively gives rsp_hit=1 and rsp_dirty=0, sends no snoop, and adds the requester's presence bit.
- R6: A read hit where another core holds the line exclusively gives rsp_dirty=1 and sends a forward snoop (snp_type=0) to the other holders. It then clears the exclusive flag unless the requester was already the only holder.
- R7: A read-for-ownership hit sends an invalidate snoop (snp_type=1) to every other holder when any exists, and sends no snoop otherwise. Afterwards only the requester's bit is set and the line is exclusive. rsp_dirty=1 when the line had been exclusive to another core.
- R8: A miss picks the lowest-numbered invalid way of its set. When every way is valid, it picks the tree pseudo-LRU victim. Every accepted hit and every allocation points the tree away from the way that was used.
- R9: When a valid victim has any presence bits, the miss also sends a back-invalidate snoop (snp_type=2) whose mask is the victim's presence bits and whose snp_addr is the victim's line address. A victim with no holders gives no snoop.
- R10: A snoop mask is never empty, and a forward or invalidate snoop never includes the requesting core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_line | input | LINE_W | Requested line address (byte address without 64-byte offset) |
| req_core | input | CORE_W | Requesting core index |
| req_rfo | input | 1 | 1 = read-for-ownership, 0 = read |
| fill_valid | input | 1 | Memory data delivered to a core |
| fill_line | input | LINE_W | Line address of the fill |
| fill_core | input | CORE_W | Core receiving the fill |
| rsp_valid | output | 1 | Response for the previous cycle's accepted request |
| rsp_hit | output | 1 | Line was present |
| rsp_dirty | output | 1 | Data must come from another core's exclusive copy |
| snp_valid | output | 1 | Snoop command issued |
| snp_mask | output | NUM_CORES | Cores to snoop |
| snp_type | output | 2 | 0 forward, 1 invalidate, 2 back-invalidate |
| snp_addr | output | LINE_W | Line address of the snoop |
| miss_valid | output | 1 | Memory request issued |
| miss_addr | output | LINE_W | Line address requested from memory |

## Verification
The hardest case to reach from the ports is a back-invalidate aimed at a pseudo-LRU victim. To reach it, the bench fills every way of one set, each way owned by a different core. It then re-touches one way so that the tree no longer points at the oldest allocation, and finally misses with a fifth line. The expected victim and its holder are worked out by hand from the tree rule. The bench then misses on the evicted line again, which confirms the eviction and exercises a second victim. A separate set is filled with lines that never got a fill, so that replacement with no holders is checked to send no snoop.

// File: rtl/snf_pkg.sv
// Shared types of the snoop-filtering directory slice.
// Assumes nothing beyond IEEE 1800-2017.
package snf_pkg;
    typedef enum logic [1:0] {
        SNP_FWD     = 2'd0,
        SNP_INV     = 2'd1,
        SNP_BACKINV = 2'd2
    } snp_kind_e;
endpackage

// File: rtl/snf_slice_sel.sv
// Decides whether a line address belongs to this slice.
// The line bits are XOR-folded into SEL_W bits; SEL_W >= 1.
module snf_slice_sel #(
    parameter int LINE_W   = 10,
    parameter int SEL_W    = 2,
    parameter int SLICE_ID = 0
) (
    input  logic [LINE_W-1:0] line,
    output logic              mine
);
    logic [SEL_W-1:0] fold;

    // fold every line bit into slice bit (index mod SEL_W)
    always_comb begin
        fold = '0;
        for (int i = 0; i < LINE_W; i++) begin
            fold[i % SEL_W] = fold[i % SEL_W] ^ line[i];
        end
        mine = (fold == SEL_W'(SLICE_ID));
    end
endmodule

// File: rtl/snf_plru.sv
// Tree pseudo-LRU state for every set of the slice.
// Assumes WAYS is a power of two; node 1 is the root, children 2n and 2n+1.
module snf_plru #(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim
);
    logic [WAYS-1:0] tree_q [SETS];
    logic [WAYS-1:0] tree_nxt;

    // walk the tree for the selected set: bit 0 goes low, bit 1 goes high
    always_comb begin
        int n;
        n = 1;
        for (int l = 0; l < WAY_W; l++) begin
            n = 2 * n + int'(tree_q[rd_set][n]);
        end
        victim = WAY_W'(n - WAYS);
    end

    // point every node on the used path away from the used way
    always_comb begin
        int n;
        tree_nxt = tree_q[touch_set];
        n = 1;
        for (int l = WAY_W - 1; l >= 0; l--) begin
            tree_nxt[n] = ~touch_way[l];
            n = 2 * n + int'(touch_way[l]);
        end
    end

    // hold tree state, cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (touch_en) begin
            tree_q[touch_set] <= tree_nxt;
        end
    end
endmodule

// File: rtl/llc_snoop_dir.sv
// Tag and presence directory of one inclusive cache slice.
// Answers each accepted request one cycle later with hit/miss, snoop and
// memory request. Assumes fills and requests never share a cycle and that
// WAYS is a power of two.
module llc_snoop_dir #(
    parameter int NUM_CORES = 4,
    parameter int SETS      = 4,
    parameter int WAYS      = 4,
    parameter int LINE_W    = 10,
    parameter int SLICE_ID  = 0,
    localparam int CORE_W = $clog2(NUM_CORES),
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int TAG_W  = LINE_W - SET_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [LINE_W-1:0]    req_line,
    input  logic [CORE_W-1:0]    req_core,
    input  logic                 req_rfo,
    input  logic                 fill_valid,
    input  logic [LINE_W-1:0]    fill_line,
    input  logic [CORE_W-1:0]    fill_core,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_dirty,
    output logic                 snp_valid,
    output logic [NUM_CORES-1:0] snp_mask,
    output logic [1:0]           snp_type,
    output logic [LINE_W-1:0]    snp_addr,
    output logic                 miss_valid,
    output logic [LINE_W-1:0]    miss_addr
);
    import snf_pkg::*;

    logic [WAYS-1:0]      valid_q [SETS];
    logic [WAYS-1:0]      excl_q  [SETS];
    logic [TAG_W-1:0]     tag_q   [SETS][WAYS];
    logic [NUM_CORES-1:0] cvb_q   [SETS][WAYS];

    logic [SET_W-1:0]     r_set, f_set;
    logic [TAG_W-1:0]     r_tag, f_tag;
    logic                 r_mine, f_mine, accept;
    logic [WAYS-1:0]      r_match, f_match;
    logic                 r_hit, f_hit, free_any;
    logic [WAY_W-1:0]     hit_way, free_way, plru_way, use_way, f_way;
    logic [NUM_CORES-1:0] cur_cvb, req_bit, others, fill_bit;
    logic                 cur_excl, excl_other;

    assign r_set = req_line[SET_W-1:0];
    assign r_tag = req_line[LINE_W-1:SET_W];
    assign f_set = fill_line[SET_W-1:0];
    assign f_tag = fill_line[LINE_W-1:SET_W];

    snf_slice_sel #(.LINE_W(LINE_W), .SEL_W(CORE_W), .SLICE_ID(SLICE_ID))
        u_req_sel (.line(req_line), .mine(r_mine));
    snf_slice_sel #(.LINE_W(LINE_W), .SEL_W(CORE_W), .SLICE_ID(SLICE_ID))
        u_fill_sel (.line(fill_line), .mine(f_mine));

    // per-way tag compare for request and fill lookups
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign r_match[w] = valid_q[r_set][w] && (tag_q[r_set][w] == r_tag);
        assign f_match[w] = valid_q[f_set][w] && (tag_q[f_set][w] == f_tag);
    end

    assign accept = req_valid && r_mine;

    snf_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(accept), .touch_set(r_set), .touch_way(use_way),
        .rd_set(r_set), .victim(plru_way)
    );

    // encode hit way, lowest free way and fill way
    always_comb begin
        hit_way  = '0;
        f_way    = '0;
        free_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (r_match[w]) hit_way = WAY_W'(w);
            if (f_match[w]) f_way   = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_q[r_set][w]) free_way = WAY_W'(w);
        end
    end

    // choose the way in use and derive the presence masks
    always_comb begin
        r_hit    = |r_match;
        f_hit    = |f_match;
        free_any = ~&valid_q[r_set];
        use_way  = r_hit ? hit_way : (free_any ? free_way : plru_way);
        cur_cvb  = cvb_q[r_set][use_way];
        cur_excl = excl_q[r_set][use_way];
        req_bit  = '0;
        req_bit[req_core] = 1'b1;
        fill_bit = '0;
        fill_bit[fill_core] = 1'b1;
        others     = cur_cvb & ~req_bit;
        excl_other = cur_excl && (others != '0);
    end

    // directory update and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_dirty  <= 1'b0;
            snp_valid  <= 1'b0;
            snp_mask   <= '0;
            snp_type   <= SNP_FWD;
            snp_addr   <= '0;
            miss_valid <= 1'b0;
            miss_addr  <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                excl_q[s]  <= '0;
                for (int w = 0; w < WAYS; w++) cvb_q[s][w] <= '0;
            end
        end else begin
            rsp_valid  <= 1'b0;
            snp_valid  <= 1'b0;
            miss_valid <= 1'b0;
            if (accept) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= r_hit;
                if (r_hit) begin
                    snp_addr  <= req_line;
                    snp_mask  <= others;
                    rsp_dirty <= excl_other;
                    if (req_rfo) begin
                        snp_valid <= (others != '0);
                        snp_type  <= SNP_INV;
                        cvb_q[r_set][use_way]  <= req_bit;
                        excl_q[r_set][use_way] <= 1'b1;
                    end else begin
                        snp_valid <= excl_other;
                        snp_type  <= SNP_FWD;
                        cvb_q[r_set][use_way]  <= cur_cvb | req_bit;
                        excl_q[r_set][use_way] <= cur_excl && (cur_cvb == req_bit);
                    end
                end else begin
                    rsp_dirty  <= 1'b0;
                    miss_valid <= 1'b1;
                    miss_addr  <= req_line;
                    if (!free_any && cur_cvb != '0) begin
                        snp_valid <= 1'b1;
                        snp_type  <= SNP_BACKINV;
                        snp_mask  <= cur_cvb;
                        snp_addr  <= {tag_q[r_set][use_way], r_set};
                    end
                    valid_q[r_set][use_way] <= 1'b1;
                    tag_q[r_set][use_way]   <= r_tag;
                    cvb_q[r_set][use_way]   <= '0;
                    excl_q[r_set][use_way]  <= req_rfo;
                end
            end
            if (fill_valid && f_mine && f_hit) begin
                cvb_q[f_set][f_way] <= cvb_q[f_set][f_way] | fill_bit;
            end
        end
    end
endmodule

// File: rtl/snf_chk.sv
// Temporal checks on the directory slice ports; attached by bind.
// Assumes synchronous active-low reset.
module snf_chk #(
    parameter int NUM_CORES = 4,
    localparam int CORE_W = $clog2(NUM_CORES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [CORE_W-1:0]    req_core,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic                 rsp_dirty,
    input logic                 snp_valid,
    input logic [NUM_CORES-1:0] snp_mask,
    input logic [1:0]           snp_type,
    input logic                 miss_valid
);
    // R2
    rsp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
    // R3
    miss_is_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> (rsp_valid && !rsp_hit));
    // R6
    dirty_has_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_dirty && rsp_valid |-> rsp_hit && snp_valid);
    // R9
    backinv_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_type == snf_pkg::SNP_BACKINV |-> miss_valid);
    // R10
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> snp_mask != '0);
    // R10
    no_self_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_type != snf_pkg::SNP_BACKINV |-> !snp_mask[$past(req_core)]);
endmodule

bind llc_snoop_dir snf_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty),
    .snp_valid(snp_valid), .snp_mask(snp_mask), .snp_type(snp_type),
    .miss_valid(miss_valid)
);

// File: tb/llc_snoop_dir_bench.sv
// Directed bench for the directory slice; one task per scenario.
module llc_snoop_dir_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [9:0] req_line = '0;
    logic [1:0] req_core = '0;
    logic       req_rfo = 1'b0;
    logic       fill_valid = 1'b0;
    logic [9:0] fill_line = '0;
    logic [1:0] fill_core = '0;
    logic       rsp_valid, rsp_hit, rsp_dirty, snp_valid, miss_valid;
    logic [3:0] snp_mask;
    logic [1:0] snp_type;
    logic [9:0] snp_addr, miss_addr;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    llc_snoop_dir u_llc_snoop_dir (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_line(req_line), .req_core(req_core), .req_rfo(req_rfo),
        .fill_valid(fill_valid), .fill_line(fill_line), .fill_core(fill_core),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty),
        .snp_valid(snp_valid), .snp_mask(snp_mask), .snp_type(snp_type), .snp_addr(snp_addr),
        .miss_valid(miss_valid), .miss_addr(miss_addr)
    );

    // line in slice 0: set in bits [1:0], pair-XOR of all bits is zero
    function automatic logic [9:0] ln(input logic [1:0] set, input logic [5:0] k);
        logic [1:0] low;
        low = set ^ k[1:0] ^ k[3:2] ^ k[5:4];
        return {k, low, set};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // one request cycle; outputs sampled at the next falling edge
    task automatic do_req(input logic [9:0] l, input logic [1:0] c, input logic rfo);
        @(negedge clk);
        req_valid = 1'b1; req_line = l; req_core = c; req_rfo = rfo;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [9:0] l, input logic [1:0] c);
        @(negedge clk);
        fill_valid = 1'b1; fill_line = l; fill_core = c;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic hit, input logic dirty,
                              input logic snp, input logic [3:0] mask, input logic [1:0] kind);
        check(req, "rsp_valid", 32'(rsp_valid), 1);
        check(req, "rsp_hit", 32'(rsp_hit), 32'(hit));
        check(req, "snp_valid", 32'(snp_valid), 32'(snp));
        if (hit) check(req, "rsp_dirty", 32'(rsp_dirty), 32'(dirty));
        if (snp) begin
            check(req, "snp_mask", 32'(snp_mask), 32'(mask));
            check(req, "snp_type", 32'(snp_type), 32'(kind));
        end
    endtask

    task automatic t_reset();
        check("R1", "rsp_valid", 32'(rsp_valid), 0);
        check("R1", "snp_valid", 32'(snp_valid), 0);
        check("R1", "miss_valid", 32'(miss_valid), 0);
    endtask

    task automatic t_offslice();
        do_req(ln(0, 1) ^ 10'h004, 0, 1'b0);
        check("R2", "rsp_valid", 32'(rsp_valid), 0);
        check("R2", "miss_valid", 32'(miss_valid), 0);
        check("R2", "snp_valid", 32'(snp_valid), 0);
    endtask

    task automatic t_miss_fill_read();
        do_req(ln(0, 1), 0, 1'b0);
        expect_rsp("R3", 0, 0, 0, 0, 0);
        check("R3", "miss_valid", 32'(miss_valid), 1);
        check("R3", "miss_addr", 32'(miss_addr), 32'(ln(0, 1)));
        do_fill(ln(0, 1), 0);
        do_req(ln(0, 1), 1, 1'b0);
        expect_rsp("R5", 1, 0, 0, 0, 0);
    endtask

    task automatic t_fill_absent();
        do_fill(ln(0, 2), 3);
        do_req(ln(0, 2), 3, 1'b0);
        expect_rsp("R4", 0, 0, 0, 0, 0);
        do_req(ln(0, 2), 1, 1'b1);
        expect_rsp("R4 R7", 1, 0, 0, 0, 0);
    endtask

    task automatic t_ownership();
        do_req(ln(0, 1), 2, 1'b1);
        expect_rsp("R7", 1, 0, 1, 4'b0011, 2'd1);
        do_req(ln(0, 1), 3, 1'b0);
        expect_rsp("R6", 1, 1, 1, 4'b0100, 2'd0);
        do_req(ln(0, 1), 0, 1'b0);
        expect_rsp("R6 R5", 1, 0, 0, 0, 0);
        do_req(ln(0, 1), 1, 1'b1);
        expect_rsp("R7", 1, 0, 1, 4'b1101, 2'd1);
        do_req(ln(0, 1), 1, 1'b1);
        expect_rsp("R7", 1, 0, 0, 0, 0);
    endtask

    task automatic t_evict_backinv();
        for (int k = 1; k <= 4; k++) begin
            do_req(ln(1, 6'(k)), 2'(k - 1), 1'b0);
            expect_rsp("R8", 0, 0, 0, 0, 0);
            do_fill(ln(1, 6'(k)), 2'(k - 1));
        end
        do_req(ln(1, 1), 0, 1'b0);
        expect_rsp("R8", 1, 0, 0, 0, 0);
        do_req(ln(1, 5), 0, 1'b0);
        expect_rsp("R9", 0, 0, 1, 4'b0100, 2'd2);
        check("R9", "snp_addr", 32'(snp_addr), 32'(ln(1, 3)));
        do_req(ln(1, 3), 1, 1'b0);
        expect_rsp("R8 R9", 0, 0, 1, 4'b0010, 2'd2);
        check("R8", "snp_addr", 32'(snp_addr), 32'(ln(1, 2)));
    endtask

    task automatic t_evict_empty();
        for (int k = 1; k <= 4; k++) do_req(ln(2, 6'(k)), 0, 1'b0);
        do_req(ln(2, 5), 0, 1'b0);
        expect_rsp("R9", 0, 0, 0, 0, 0);
        check("R9", "miss_addr", 32'(miss_addr), 32'(ln(2, 5)));
        do_req(ln(2, 1), 0, 1'b0);
        expect_rsp("R8", 0, 0, 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_offslice();
        t_miss_fill_read();
        t_fill_absent();
        t_ownership();
        t_evict_backinv();
        t_evict_empty();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule